// File: doc/BRIEF.md
# Virtual interrupt-controller write filter

This block sits on the path of guest writes that hit a trapped page of interrupt-controller registers. For every write it decides one of two outcomes. The write is either virtualized, meaning it goes to the same offset of a shadow register page through a write port, or it is refused, meaning it produces an access-exit pulse that carries the offending offset. The set of offsets that can be virtualized depends on two mode inputs. One enables full register virtualization and the other enables virtual interrupt delivery.

A guest operation is one iteration of a repeated string instruction, one execution of any other instruction, or one event delivery. Within a single operation, only one distinct offset may be virtualized. The block latches the first virtualized offset of the operation. Any later write in the same operation to a different offset is refused. The surrounding pipeline marks the end of each operation with a boundary strobe, which clears the latch.

Each write costs one request cycle. The decision, the shadow write and the updated latch appear together on registered outputs at the next clock edge.

Top module: `vic_wr_filter`

## Requirements
- R1: With both mode inputs low, a write is virtualized only if it starts at offset 0x080. Any other start offset produces an exit.
- R2: With `mode_regv` low and `mode_vdel` high, a write is virtualized only if it starts at offset 0x080, 0x0B0 or 0x300. Any other start offset, including one inside those words, produces an exit.
- R3: With `mode_regv` high, `mode_vdel` has no effect on the accept set. A write is virtualized only if all of its bytes lie in one 4-byte word whose base is one of 0x020, 0x080, 0x0B0, 0x0D0, 0x0E0, 0x0F0, 0x280, 0x300, 0x310, 0x320, 0x330, 0x340, 0x350, 0x360, 0x370, 0x380 or 0x3E0.
- R4: The write length in bytes is `wr_len_m1`+1. A write that starts inside an accepted word but whose last byte falls beyond byte 3 of that word produces an exit.
- R5: A write accepted in cycle N raises `shw_en` for exactly cycle N+1. In that cycle `shw_addr`, `shw_data` and `shw_len_m1` carry the request's offset, data and length. When `shw_en` is low, those fields read 0.
- R6: Once an offset has been virtualized in an operation, a later write in the same operation to a different start offset produces an exit. A later write to the same start offset is still virtualized, subject to R1 to R4.
- R7: A cycle with `op_end` high clears the latch at the next edge. A write presented in that same cycle is judged as the first write of a new operation.
- R8: Every request produces exactly one of `dec_virt` or `dec_exit`, as a one-cycle pulse in the following cycle. `exit_off` carries the refused offset while `dec_exit` is high and reads 0 otherwise. A cycle with no request produces neither pulse.
- R9: After reset, every output is 0.
- R10: `op_lat_valid` and `op_lat_off` report the first offset virtualized in the current operation. Their values are unchanged until the next boundary strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request present this cycle |
| wr_offset | input | 12 | Page offset of the first written byte |
| wr_len_m1 | input | LEN_W (2) | Write length in bytes minus one |
| wr_data | input | DATA_W (32) | Write data |
| op_end | input | 1 | Last cycle of the current guest operation |
| mode_regv | input | 1 | Full register virtualization enable |
| mode_vdel | input | 1 | Virtual interrupt delivery enable |
| dec_virt | output | 1 | Pulse: previous request was virtualized |
| dec_exit | output | 1 | Pulse: previous request raised an access exit |
| exit_off | output | 12 | Offset of the refused request |
| shw_en | output | 1 | Shadow page write enable |
| shw_addr | output | 12 | Shadow page write offset |
| shw_data | output | DATA_W (32) | Shadow page write data |
| shw_len_m1 | output | LEN_W (2) | Shadow page write length minus one |
| op_lat_valid | output | 1 | An offset is latched for this operation |
| op_lat_off | output | 12 | Latched offset |

## Verification
The bench applies directed writes in each of the three modes. Each mode is tried at an accepted word base, at an unaligned start inside that word, at a word that only a richer mode accepts, and at a start that overruns byte 3. Together these separate the three accept sets and the length rule.

Operation sequences cover several cases: a repeat of the same offset, a second distinct offset, and a write in the same cycle as the boundary strobe. These show whether the latch compares start offsets and whether the strobe takes effect before or after a concurrent write.

Constrained random traffic then concentrates offsets on accepted words, with random low nibbles and lengths, mixes in fully random offsets, and toggles the modes and strobes. This catches slips in individual table entries.

// File: rtl/vic_wf_pkg.sv
package vic_wf_pkg;

  localparam int PAGE_OFF_W = 12;

  typedef enum logic [1:0] {
    MODE_BASIC = 2'd0,
    MODE_DELIV = 2'd1,
    MODE_REGV  = 2'd2
  } vic_mode_e;

  function automatic vic_mode_e mode_of(input logic regv, input logic vdel);
    if (regv)      return MODE_REGV;
    else if (vdel) return MODE_DELIV;
    else           return MODE_BASIC;
  endfunction

  // Word index (offset bits 11:4) of every register word open to full virtualization.
  function automatic logic word_listed(input logic [7:0] w);
    case (w)
      8'h02, 8'h08, 8'h0B, 8'h0D, 8'h0E, 8'h0F,
      8'h28, 8'h30, 8'h31, 8'h32, 8'h33, 8'h34,
      8'h35, 8'h36, 8'h37, 8'h38, 8'h3E: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  // True when a write of (len_m1+1) bytes starting at low nibble lo stays in bytes 0..3.
  function automatic logic fits_word(input logic [3:0] lo, input logic [2:0] len_m1);
    logic [4:0] last_byte;
    last_byte = {1'b0, lo} + {2'b00, len_m1};
    return last_byte <= 5'd3;
  endfunction

  function automatic logic exact_start(input logic [PAGE_OFF_W-1:0] off, input vic_mode_e m);
    case (m)
      MODE_BASIC: return off == 12'h080;
      MODE_DELIV: return (off == 12'h080) || (off == 12'h0B0) || (off == 12'h300);
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/vic_wf_decode.sv
module vic_wf_decode
  import vic_wf_pkg::*;
#(
  parameter int LEN_W = 2
) (
  input  logic [PAGE_OFF_W-1:0] off,
  input  logic [LEN_W-1:0]      len_m1,
  input  logic                  regv,
  input  logic                  vdel,
  output logic                  hit,
  output logic                  hit_listed,
  output logic                  hit_fits
);
  vic_mode_e  mode;
  logic [2:0] len_ext;

  assign mode    = mode_of(regv, vdel);
  assign len_ext = 3'(len_m1);

  always_comb begin
    hit_listed = word_listed(off[11:4]);
    hit_fits   = fits_word(off[3:0], len_ext);
    if (mode == MODE_REGV) hit = hit_listed && hit_fits;
    else                   hit = exact_start(off, mode) && hit_fits;
  end
endmodule

// File: rtl/vic_wf_optrack.sv
module vic_wf_optrack
  import vic_wf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  hit,
  input  logic [PAGE_OFF_W-1:0] off,
  input  logic                  op_end,
  output logic                  grant,
  output logic                  blocked,
  output logic                  lat_valid,
  output logic [PAGE_OFF_W-1:0] lat_off
);
  logic held;

  // A strobe in the same cycle ends the old operation before this request is judged.
  assign held    = lat_valid && !op_end;
  assign blocked = held && (lat_off != off);
  assign grant   = req && hit && !blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_valid <= 1'b0;
      lat_off   <= '0;
    end else if (grant) begin
      lat_valid <= 1'b1;
      lat_off   <= off;
    end else if (op_end) begin
      lat_valid <= 1'b0;
      lat_off   <= '0;
    end
  end
endmodule

// File: rtl/vic_wf_outreg.sv
module vic_wf_outreg
  import vic_wf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  grant,
  input  logic [PAGE_OFF_W-1:0] off,
  input  logic [LEN_W-1:0]      len_m1,
  input  logic [DATA_W-1:0]     data,
  output logic                  virt,
  output logic                  exit_p,
  output logic [PAGE_OFF_W-1:0] exit_off,
  output logic [PAGE_OFF_W-1:0] w_addr,
  output logic [DATA_W-1:0]     w_data,
  output logic [LEN_W-1:0]      w_len_m1
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      virt     <= 1'b0;
      exit_p   <= 1'b0;
      exit_off <= '0;
      w_addr   <= '0;
      w_data   <= '0;
      w_len_m1 <= '0;
    end else begin
      virt     <= grant;
      exit_p   <= req && !grant;
      exit_off <= (req && !grant) ? off : '0;
      w_addr   <= grant ? off : '0;
      w_data   <= grant ? data : '0;
      w_len_m1 <= grant ? len_m1 : '0;
    end
  end
endmodule

// File: rtl/vic_wr_filter.sv
module vic_wr_filter
  import vic_wf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W / 8)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [PAGE_OFF_W-1:0] wr_offset,
  input  logic [LEN_W-1:0]      wr_len_m1,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  op_end,
  input  logic                  mode_regv,
  input  logic                  mode_vdel,
  output logic                  dec_virt,
  output logic                  dec_exit,
  output logic [PAGE_OFF_W-1:0] exit_off,
  output logic                  shw_en,
  output logic [PAGE_OFF_W-1:0] shw_addr,
  output logic [DATA_W-1:0]     shw_data,
  output logic [LEN_W-1:0]      shw_len_m1,
  output logic                  op_lat_valid,
  output logic [PAGE_OFF_W-1:0] op_lat_off
);
  // Named internal events, visible to the bound checker.
  logic acc_hit;
  logic acc_listed;
  logic acc_fits;
  logic acc_grant;
  logic acc_blocked;
  logic virt_q;

  vic_wf_decode #(.LEN_W(LEN_W)) u_decode (
    .off        (wr_offset),
    .len_m1     (wr_len_m1),
    .regv       (mode_regv),
    .vdel       (mode_vdel),
    .hit        (acc_hit),
    .hit_listed (acc_listed),
    .hit_fits   (acc_fits)
  );

  vic_wf_optrack u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (wr_valid),
    .hit       (acc_hit),
    .off       (wr_offset),
    .op_end    (op_end),
    .grant     (acc_grant),
    .blocked   (acc_blocked),
    .lat_valid (op_lat_valid),
    .lat_off   (op_lat_off)
  );

  vic_wf_outreg #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (wr_valid),
    .grant    (acc_grant),
    .off      (wr_offset),
    .len_m1   (wr_len_m1),
    .data     (wr_data),
    .virt     (virt_q),
    .exit_p   (dec_exit),
    .exit_off (exit_off),
    .w_addr   (shw_addr),
    .w_data   (shw_data),
    .w_len_m1 (shw_len_m1)
  );

  assign dec_virt = virt_q;
  assign shw_en   = virt_q;
endmodule

// File: rtl/vic_wr_filter_chk.sv
module vic_wr_filter_chk #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [11:0]       wr_offset,
  input logic [DATA_W-1:0] wr_data,
  input logic              op_end,
  input logic              mode_regv,
  input logic              mode_vdel,
  input logic              dec_virt,
  input logic              dec_exit,
  input logic [11:0]       shw_addr,
  input logic [DATA_W-1:0] shw_data,
  input logic [LEN_W-1:0]  shw_len_m1,
  input logic              op_lat_valid,
  input logic [11:0]       op_lat_off
);
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_virt && dec_exit));

  p_pulse_has_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_virt || dec_exit) |-> $past(wr_valid));

  p_basic_080_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_virt && !$past(mode_regv) && !$past(mode_vdel)) |-> shw_addr == 12'h080);

  p_deliv_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_virt && !$past(mode_regv) && $past(mode_vdel)) |->
      (shw_addr == 12'h080 || shw_addr == 12'h0B0 || shw_addr == 12'h300));

  p_in_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_virt |-> ({3'b000, shw_addr[1:0]} + 5'(shw_len_m1)) <= 5'd3 && shw_addr[3:2] == 2'b00);

  p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_virt |-> (shw_addr == $past(wr_offset) && shw_data == $past(wr_data)));

  p_one_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_virt |-> (op_lat_valid && op_lat_off == shw_addr));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_end && !wr_valid) |=> !op_lat_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_lat_valid && !op_end) |=> (op_lat_valid && op_lat_off == $past(op_lat_off)));
endmodule

bind vic_wr_filter vic_wr_filter_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_offset    (wr_offset),
  .wr_data      (wr_data),
  .op_end       (op_end),
  .mode_regv    (mode_regv),
  .mode_vdel    (mode_vdel),
  .dec_virt     (dec_virt),
  .dec_exit     (dec_exit),
  .shw_addr     (shw_addr),
  .shw_data     (shw_data),
  .shw_len_m1   (shw_len_m1),
  .op_lat_valid (op_lat_valid),
  .op_lat_off   (op_lat_off)
);

// File: tb/vic_wr_filter_tb.sv
`timescale 1ns/1ps
module vic_wr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [11:0] wr_offset = '0;
  logic [1:0]  wr_len_m1 = '0;
  logic [31:0] wr_data = '0;
  logic        op_end = 1'b0;
  logic        mode_regv = 1'b0;
  logic        mode_vdel = 1'b0;
  logic        dec_virt, dec_exit, shw_en, op_lat_valid;
  logic [11:0] exit_off, shw_addr, op_lat_off;
  logic [31:0] shw_data;
  logic [1:0]  shw_len_m1;

  int nvec = 0;
  int nbad = 0;
  bit m_lv = 0;
  logic [11:0] m_lo = '0;
  bit done = 0;

  always #4 clk = ~clk;

  vic_wr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_offset(wr_offset),
    .wr_len_m1(wr_len_m1), .wr_data(wr_data), .op_end(op_end),
    .mode_regv(mode_regv), .mode_vdel(mode_vdel), .dec_virt(dec_virt),
    .dec_exit(dec_exit), .exit_off(exit_off), .shw_en(shw_en),
    .shw_addr(shw_addr), .shw_data(shw_data), .shw_len_m1(shw_len_m1),
    .op_lat_valid(op_lat_valid), .op_lat_off(op_lat_off)
  );

  // Reference accept rule, written as range arithmetic.
  function automatic bit ref_ok(logic [11:0] o, int nb, bit rv, bit vd);
    int bases[17] = '{'h020, 'h080, 'h0B0, 'h0D0, 'h0E0, 'h0F0, 'h280, 'h300, 'h310,
                      'h320, 'h330, 'h340, 'h350, 'h360, 'h370, 'h380, 'h3E0};
    if (rv) begin
      foreach (bases[i])
        if (int'(o) >= bases[i] && int'(o) + nb - 1 <= bases[i] + 3) return 1;
      return 0;
    end
    if (vd) return (o == 12'h080) || (o == 12'h0B0) || (o == 12'h300);
    return o == 12'h080;
  endfunction

  task automatic cmp(string tag, string what, longint act, longint exp);
    if (act != exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [11:0] o, logic [1:0] lm1, logic [31:0] d,
                      bit oe, bit rv, bit vd, string tag);
    bit g, held;
    wr_valid = v; wr_offset = o; wr_len_m1 = lm1; wr_data = d;
    op_end = oe; mode_regv = rv; mode_vdel = vd;
    held = m_lv && !oe;
    g = v && ref_ok(o, int'(lm1) + 1, rv, vd) && (!held || m_lo == o);
    if (g) begin m_lv = 1; m_lo = o; end
    else if (oe) begin m_lv = 0; m_lo = '0; end
    @(negedge clk);
    nvec++;
    cmp(tag, "dec_virt", dec_virt, g);
    cmp(tag, "dec_exit", dec_exit, v && !g);
    cmp(tag, "exit_off", exit_off, (v && !g) ? o : 12'h0);
    cmp(tag, "shw_en", shw_en, g);
    cmp(tag, "shw_addr", shw_addr, g ? o : 12'h0);
    cmp(tag, "shw_data", shw_data, g ? d : 32'h0);
    cmp(tag, "shw_len_m1", shw_len_m1, g ? lm1 : 2'h0);
    cmp(tag, "op_lat_valid", op_lat_valid, m_lv);
    cmp(tag, "op_lat_off", op_lat_off, m_lo);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [11:0] hot [18] = '{12'h020, 12'h080, 12'h0B0, 12'h0D0, 12'h0E0, 12'h0F0,
                              12'h280, 12'h300, 12'h310, 12'h320, 12'h330, 12'h340,
                              12'h350, 12'h360, 12'h370, 12'h380, 12'h3E0, 12'h290};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9: reset state
    nvec++;
    cmp("R9", "outputs", {dec_virt, dec_exit, shw_en, op_lat_valid, exit_off, shw_addr, op_lat_off}, 0);
    cmp("R9", "shw_data", shw_data, 0);
    rst_n = 1'b1;
    step(0, 12'h080, 0, 0, 0, 0, 0, "R8_idle");
    // R1 basic mode
    step(1, 12'h080, 3, 32'hA5A5_0001, 1, 0, 0, "R1");
    step(1, 12'h0B0, 0, 32'h2, 1, 0, 0, "R1");
    step(1, 12'h081, 0, 32'h3, 1, 0, 0, "R1");
    // R2 delivery mode
    step(1, 12'h0B0, 3, 32'h4, 1, 0, 1, "R2");
    step(1, 12'h300, 1, 32'h5, 1, 0, 1, "R2");
    step(1, 12'h301, 0, 32'h6, 1, 0, 1, "R2");
    step(1, 12'h310, 0, 32'h7, 1, 0, 1, "R2");
    // R3 full register mode, delivery ignored
    step(1, 12'h3E2, 1, 32'h8, 1, 1, 0, "R3");
    step(1, 12'h372, 0, 32'h9, 1, 1, 1, "R3");
    step(1, 12'h290, 0, 32'hA, 1, 1, 1, "R3");
    step(1, 12'h024, 0, 32'hB, 1, 1, 0, "R3");
    // R4 overrun
    step(1, 12'h3E2, 2, 32'hC, 1, 1, 0, "R4");
    step(1, 12'h081, 3, 32'hD, 1, 1, 0, "R4");
    // R6 / R10 operation sequence
    step(1, 12'h0D0, 3, 32'h11, 0, 1, 0, "R10");
    step(1, 12'h0E0, 3, 32'h12, 0, 1, 0, "R6");
    step(1, 12'h0D0, 1, 32'h13, 0, 1, 0, "R6");
    step(0, 12'h0, 0, 0, 0, 1, 0, "R10");
    // R7 strobe together with a write to another offset
    step(1, 12'h0F0, 3, 32'h14, 1, 1, 0, "R7");
    step(0, 12'h0, 0, 0, 1, 1, 0, "R7");
    step(1, 12'h380, 3, 32'h15, 0, 1, 0, "R7");
    step(0, 12'h0, 0, 0, 1, 1, 0, "R7");
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] o;
      bit rv, vd;
      string tag;
      if ($urandom % 4 == 0) o = 12'($urandom);
      else o = hot[$urandom % 18] | 12'($urandom % 4);
      rv = ($urandom % 2) == 1;
      vd = ($urandom % 2) == 1;
      tag = rv ? "R3" : (vd ? "R2" : "R1");
      step(($urandom % 5) != 0, o, 2'($urandom), $urandom, ($urandom % 6) == 0, rv, vd, tag);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule